// File: doc/BRIEF.md
# Clock Generator Serial Control Register Slave

This block is the two-wire serial control slave of a multi-output clock generator. It oversamples the bus clock and data lines in the system clock domain and recognises start and stop conditions and bit edges. When its 7-bit device address is seen, it acknowledges the transfer. In a write, the block acknowledges the first two bytes after the address and discards them. Every data byte after those two is stored in the next control register, starting at register 0. In a read, the block first returns a byte count and then the registers in index order.

The registers hold several groups of settings. The first group selects whether the output frequency comes from the hardware straps or from a 6-bit software code. Other fields force all clock outputs to tristate, set the spread-spectrum mode and depth, and enable each output clock. Two 3-bit skew codes set the skew from the CPU clock to the memory clocks and to the chipset clocks. Five further registers are general-purpose configuration storage. Register 1 reads back the hardware strap pins in its upper five bits. Registers 11 and 12 hold fixed identification values. The field outputs drive clock gating and mode logic elsewhere. The registers return to their power-up values only on reset, never through bus activity.

Top module: `clkctl_regs`

## Requirements
- R1: After reset the registers hold these values: register 0 = 0x00, register 1 bits 2:0 = 001, registers 2, 3 and 4 = 0xFF, register 5 = 0x93, registers 6 to 10 = 0x00. The slave does not drive SDA.
- R2: The first byte after a START is the 7-bit address in bits 7:1 (default 0x69) and the direction in bit 0 (0 = write, 1 = read). On a match the slave pulls SDA low during the ninth clock. On a mismatch it does not acknowledge, and the rest of the transfer has no effect.
- R3: In a write, the two bytes after the address are acknowledged and their values are ignored. Each following data byte is acknowledged and stored in register 0, then register 1, then register 2, and so on.
- R4: A STOP or a repeated START ends the transfer. The next write stores its first data byte in register 0 again.
- R5: Data bytes beyond register 12 are acknowledged and discarded.
- R6: Registers 11 and 12 read 0x50 and 0x12, and writes to them have no effect. Register 1 bits 7:3 read the strap input, with bit 7 = strap_fs[0] down to bit 3 = strap_fs[4]. Writes to those five bits have no effect.
- R7: A read returns 0x0D (the register count) first, then register 0, register 1 and so on. An index past 12 reads 0x00. After a master NACK the slave releases SDA.
- R8: Register 0 drives the frequency fields. sw_freq_sel[5] = bit 1, sw_freq_sel[4] = bit 2 and sw_freq_sel[3:0] = bits 7:4. freq_from_sw = bit 3 and clk_tristate = bit 0.
- R9: Register 1 drives the spread fields: spread_quarter = bit 2, spread_on = bit 1 and spread_center = bit 0.
- R10: Registers 2, 3 and 4 drive out_en_bank0, out_en_bank1 and out_en_bank2 bit for bit. Register 5 drives the remaining clock fields: cpu_mem_skew = bits 7:5, cpu_chip_skew = bits 4:2 and cpu_clk_en = bits 1:0. aux_cfg carries register 6 in bits 7:0, up to register 10 in bits 39:32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| strap_fs | input | 5 | Latched hardware frequency straps |
| sw_freq_sel | output | 6 | Software frequency select code |
| freq_from_sw | output | 1 | 1 = frequency from software code |
| clk_tristate | output | 1 | 1 = tristate all clock outputs |
| spread_quarter | output | 1 | 1 = 0.25 % spread, 0 = 0.5 % |
| spread_on | output | 1 | Spread-spectrum enable |
| spread_center | output | 1 | 1 = center spread, 0 = down spread |
| out_en_bank0 | output | 8 | Output enables from register 2 |
| out_en_bank1 | output | 8 | Output enables from register 3 |
| out_en_bank2 | output | 8 | Output enables from register 4 |
| cpu_mem_skew | output | 3 | CPU-to-memory clock skew code |
| cpu_chip_skew | output | 3 | CPU-to-chipset clock skew code |
| cpu_clk_en | output | 2 | CPU clock enables |
| aux_cfg | output | 40 | Registers 6 to 10, register 6 lowest |

## Verification
The hardest case to reach from the ports is a long write that runs past the identification registers. The stimulus must first fill every writable register and then push bytes into registers 11 and 12 and past the end. Only then can the bench show that acknowledges continue while nothing changes. The bench sends a sixteen-byte write after a different pattern has already been stored. It then reads all registers back and expects the earlier values in registers 6 to 10 to be replaced only by the first eleven bytes. The repeated-START restart is also hard to reach. The bench holds SCL low after a data acknowledge and opens a new transfer without a STOP. The next single data byte then shows whether the pointer went back to register 0.

// File: rtl/clkctl_pkg.sv
// Shared constants and types for the clock control register slave.
// Assumes a fixed register map of 13 entries, 11 of them writable.
package clkctl_pkg;
    localparam int REG_NUM = 13;
    localparam int RW_NUM  = 11;
    localparam int IDX_W   = $clog2(REG_NUM + 1);
    localparam int AUX_W   = (RW_NUM - 6) * 8;

    typedef logic [IDX_W-1:0] idx_t;

    typedef enum logic [2:0] {
        BUS_IDLE,
        BUS_RX,
        BUS_RX_ACK,
        BUS_TX,
        BUS_TX_ACK
    } bus_st_t;

    // Power-up value of a writable register
    function automatic logic [7:0] pwr_default(input int idx);
        logic [7:0] v;
        case (idx)
            1:       v = 8'h01;
            2, 3, 4: v = 8'hFF;
            5:       v = 8'h93;
            default: v = 8'h00;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/clkctl_line_sync.sv
// Synchronizes one bus line into the system clock domain and flags its edges.
// Assumes the line idles high; STAGES must be at least 2.
module clkctl_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] pipe;
    logic              prev;

    // Shift the line through the synchronizer and keep the last settled value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '1;
            prev <= 1'b1;
        end else begin
            pipe <= {pipe[STAGES-2:0], din};
            prev <= pipe[STAGES-1];
        end
    end

    assign lvl  = pipe[STAGES-1];
    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;
endmodule

// File: rtl/clkctl_bus_fsm.sv
// Two-wire slave protocol engine: address match, acknowledges, byte
// reception into a register pointer and byte transmission for reads.
// Assumes edge and start/stop strobes come from synchronized lines.
module clkctl_bus_fsm
    import clkctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       sda_lvl,
    input  logic       start_evt,
    input  logic       stop_evt,
    input  logic [7:0] rd_data,
    output logic       sda_oe,
    output logic       wr_en,
    output idx_t       wr_idx,
    output logic [7:0] wr_data,
    output idx_t       ptr
);
    localparam idx_t       PTR_END  = idx_t'(REG_NUM);
    localparam logic [7:0] BYTE_CNT = 8'(REG_NUM);

    bus_st_t    state;
    logic [3:0] bit_cnt;
    logic [7:0] shreg;
    logic [1:0] byte_no;
    logic       is_read;

    // Protocol sequencing, one bus event per system clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= BUS_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            byte_no <= '0;
            is_read <= 1'b0;
            ptr     <= '0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_evt) begin
                state   <= BUS_RX;
                bit_cnt <= '0;
                byte_no <= '0;
                is_read <= 1'b0;
                ptr     <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_evt) begin
                state  <= BUS_IDLE;
                ptr    <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    BUS_RX: begin
                        if (scl_rise && bit_cnt != 4'd8) begin
                            shreg   <= {shreg[6:0], sda_lvl};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            if (byte_no == 2'd0) begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    is_read <= shreg[0];
                                    sda_oe  <= 1'b1;
                                    byte_no <= 2'd1;
                                    state   <= BUS_RX_ACK;
                                end else begin
                                    state <= BUS_IDLE;
                                end
                            end else begin
                                sda_oe <= 1'b1;
                                state  <= BUS_RX_ACK;
                                if (byte_no == 2'd3) begin
                                    wr_en   <= (ptr < PTR_END);
                                    wr_idx  <= ptr;
                                    wr_data <= shreg;
                                    if (ptr < PTR_END) ptr <= ptr + idx_t'(1);
                                end else begin
                                    byte_no <= byte_no + 2'd1;
                                end
                            end
                        end
                    end
                    BUS_RX_ACK: begin
                        if (scl_fall) begin
                            if (is_read) begin
                                shreg   <= BYTE_CNT;
                                sda_oe  <= ~BYTE_CNT[7];
                                bit_cnt <= 4'd1;
                                state   <= BUS_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= BUS_RX;
                            end
                        end
                    end
                    BUS_TX: begin
                        if (scl_fall) begin
                            if (bit_cnt == 4'd8) begin
                                sda_oe  <= 1'b0;
                                bit_cnt <= '0;
                                state   <= BUS_TX_ACK;
                            end else begin
                                shreg   <= {shreg[6:0], 1'b0};
                                sda_oe  <= ~shreg[6];
                                bit_cnt <= bit_cnt + 4'd1;
                            end
                        end
                    end
                    BUS_TX_ACK: begin
                        if (scl_rise && sda_lvl) begin
                            state <= BUS_IDLE;
                        end else if (scl_fall) begin
                            shreg   <= rd_data;
                            sda_oe  <= ~rd_data[7];
                            bit_cnt <= 4'd1;
                            state   <= BUS_TX;
                            if (ptr < PTR_END) ptr <= ptr + idx_t'(1);
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/clkctl_regfile.sv
// Control register storage with power-up defaults, strap readback and
// fixed identification bytes. Assumes one write strobe per cycle at most.
module clkctl_regfile
    import clkctl_pkg::*;
#(
    parameter logic [7:0] ID_HI = 8'h50,
    parameter logic [7:0] ID_LO = 8'h12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  idx_t                  wr_idx,
    input  logic [7:0]            wr_data,
    input  idx_t                  rd_idx,
    input  logic [4:0]            strap,
    output logic [7:0]            rd_data,
    output logic [RW_NUM*8-1:0]   cfg_flat
);
    for (genvar g = 0; g < RW_NUM; g++) begin : g_reg
        localparam logic [7:0] MASK = (g == 1) ? 8'h07 : 8'hFF;
        logic [7:0] q;

        // Hold one register; defaults only on reset
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= pwr_default(g);
            else if (wr_en && wr_idx == idx_t'(g))
                q <= wr_data & MASK;
        end

        assign cfg_flat[g*8 +: 8] = q;
    end

    // Read mux over storage, strap readback and identification bytes
    always_comb begin
        rd_data = 8'h00;
        if (rd_idx == idx_t'(1))
            rd_data = {strap[0], strap[1], strap[2], strap[3], strap[4], cfg_flat[10:8]};
        else if (rd_idx < idx_t'(RW_NUM))
            rd_data = cfg_flat[int'(rd_idx)*8 +: 8];
        else if (rd_idx == idx_t'(RW_NUM))
            rd_data = ID_HI;
        else if (rd_idx == idx_t'(RW_NUM + 1))
            rd_data = ID_LO;
    end
endmodule

// File: rtl/clkctl_regs.sv
// Top of the clock control slave: line synchronizers, protocol engine and
// register file, with register fields mapped to named outputs.
// Assumes sda_i is the wired bus value, including this slave's own pull-down.
module clkctl_regs
    import clkctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter logic [7:0] ID_HI       = 8'h50,
    parameter logic [7:0] ID_LO       = 8'h12,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe_o,
    input  logic [4:0]       strap_fs,
    output logic [5:0]       sw_freq_sel,
    output logic             freq_from_sw,
    output logic             clk_tristate,
    output logic             spread_quarter,
    output logic             spread_on,
    output logic             spread_center,
    output logic [7:0]       out_en_bank0,
    output logic [7:0]       out_en_bank1,
    output logic [7:0]       out_en_bank2,
    output logic [2:0]       cpu_mem_skew,
    output logic [2:0]       cpu_chip_skew,
    output logic [1:0]       cpu_clk_en,
    output logic [AUX_W-1:0] aux_cfg
);
    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;
    logic start_evt, stop_evt;
    logic wr_en;
    idx_t wr_idx, ptr;
    logic [7:0] wr_data, rd_data;
    logic [RW_NUM*8-1:0] cfg_flat;
    logic unused_reg1_hi;

    clkctl_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .din(scl_i),
        .lvl(scl_lvl), .rise(scl_rise), .fall(scl_fall)
    );

    clkctl_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .din(sda_i),
        .lvl(sda_lvl), .rise(sda_rise), .fall(sda_fall)
    );

    assign start_evt = scl_lvl & sda_fall;
    assign stop_evt  = scl_lvl & sda_rise;

    clkctl_bus_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
        .start_evt(start_evt), .stop_evt(stop_evt),
        .rd_data(rd_data), .sda_oe(sda_oe_o),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .ptr(ptr)
    );

    clkctl_regfile #(.ID_HI(ID_HI), .ID_LO(ID_LO)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(ptr), .strap(strap_fs),
        .rd_data(rd_data), .cfg_flat(cfg_flat)
    );

    assign sw_freq_sel    = {cfg_flat[1], cfg_flat[2], cfg_flat[7:4]};
    assign freq_from_sw   = cfg_flat[3];
    assign clk_tristate   = cfg_flat[0];
    assign spread_quarter = cfg_flat[10];
    assign spread_on      = cfg_flat[9];
    assign spread_center  = cfg_flat[8];
    assign unused_reg1_hi = ^cfg_flat[15:11];
    assign out_en_bank0   = cfg_flat[23:16];
    assign out_en_bank1   = cfg_flat[31:24];
    assign out_en_bank2   = cfg_flat[39:32];
    assign cpu_mem_skew   = cfg_flat[47:45];
    assign cpu_chip_skew  = cfg_flat[44:42];
    assign cpu_clk_en     = cfg_flat[41:40];
    assign aux_cfg        = cfg_flat[RW_NUM*8-1:48];
endmodule

// File: rtl/clkctl_regs_chk.sv
// Property checker for the clock control slave, attached by bind.
// Assumes the internal strobe and pointer names of clkctl_regs.
module clkctl_regs_chk
    import clkctl_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             sda_oe,
    input logic             scl_lvl,
    input logic             stop_evt,
    input logic             wr_en,
    input idx_t             wr_idx,
    input logic [7:0]       wr_data,
    input idx_t             ptr,
    input logic [7:0]       bank0,
    input logic [1:0]       cpu_en,
    input logic [2:0]       mem_skew,
    input logic [AUX_W-1:0] aux
);
    // R1
    reset_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (bank0 == 8'hFF && cpu_en == 2'b11 && mem_skew == 3'b100 && aux == '0 && !sda_oe));

    // R2
    ack_drive_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_lvl);

    // R3
    bank0_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == idx_t'(2)) |=> (bank0 == $past(wr_data)));

    // R4
    stop_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (ptr == '0));

    // R6
    ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx >= idx_t'(RW_NUM)) |=> ($stable(aux) && $stable(bank0) && $stable(cpu_en) && $stable(mem_skew)));
endmodule

bind clkctl_regs clkctl_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .scl_lvl(scl_lvl),
    .stop_evt(stop_evt), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .ptr(ptr), .bank0(out_en_bank0), .cpu_en(cpu_clk_en),
    .mem_skew(cpu_mem_skew), .aux(aux_cfg)
);

// File: tb/clkctl_regs_tb_top.sv
// Bench: bit-banged bus master, behavioural register model, per-clock
// comparison of the field outputs while the bus is quiet.
module clkctl_regs_tb_top;
    localparam int Q = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic        sda_bus;
    logic [4:0]  strap = 5'b01101;
    logic [5:0]  sw_freq_sel;
    logic        freq_from_sw, clk_tristate, spread_quarter, spread_on, spread_center;
    logic [7:0]  bank0, bank1, bank2;
    logic [2:0]  mem_skew, chip_skew;
    logic [1:0]  cpu_en;
    logic [39:0] aux;

    assign sda_bus = sda_m & ~sda_oe;

    clkctl_regs dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
        .strap_fs(strap), .sw_freq_sel(sw_freq_sel), .freq_from_sw(freq_from_sw),
        .clk_tristate(clk_tristate), .spread_quarter(spread_quarter),
        .spread_on(spread_on), .spread_center(spread_center),
        .out_en_bank0(bank0), .out_en_bank1(bank1), .out_en_bank2(bank2),
        .cpu_mem_skew(mem_skew), .cpu_chip_skew(chip_skew),
        .cpu_clk_en(cpu_en), .aux_cfg(aux)
    );

    int   n_chk = 0;
    int   n_bad = 0;
    bit   quiet = 1'b0;
    bit   done  = 1'b0;
    logic [7:0] mreg [13];
    logic [7:0] wq [$];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_reset();
        for (int i = 0; i < 13; i++) mreg[i] = 8'h00;
        mreg[1] = 8'h01; mreg[2] = 8'hFF; mreg[3] = 8'hFF; mreg[4] = 8'hFF; mreg[5] = 8'h93;
        mreg[11] = 8'h50; mreg[12] = 8'h12;
    endtask

    function automatic logic [7:0] model_read(input int i);
        if (i == 1) return {strap[0], strap[1], strap[2], strap[3], strap[4], mreg[1][2:0]};
        if (i < 13) return mreg[i];
        return 8'h00;
    endfunction

    // Per-clock comparison of all field outputs against the model
    always @(negedge clk) begin
        if (quiet && rst_n && !done) begin
            chk("R8 reg0 fields", {sw_freq_sel, freq_from_sw, clk_tristate},
                {mreg[0][1], mreg[0][2], mreg[0][7:4], mreg[0][3], mreg[0][0]});
            chk("R9 spread fields", {spread_quarter, spread_on, spread_center}, mreg[1][2:0]);
            chk("R10 enables skew aux", {bank0, bank1, bank2, mem_skew, chip_skew, cpu_en, aux},
                {mreg[2], mreg[3], mreg[4], mreg[5], mreg[10], mreg[9], mreg[8], mreg[7], mreg[6]});
        end
    end

    task automatic bus_start();
        quiet = 1'b0;
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
        quiet = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q / 2);
        ack = ~sda_bus;
        tick(Q / 2);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic master_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1'b1; tick(Q / 2);
            b[i] = sda_bus;
            tick(Q / 2);
            scl_m = 1'b0;
        end
        tick(Q / 2);
        sda_m = master_ack ? 1'b0 : 1'b1;
        tick(Q);
        scl_m = 1'b1; tick(Q);
        scl_m = 1'b0; tick(Q / 2);
        sda_m = 1'b1;
    endtask

    // Write: address, two ignored bytes, then the queued data bytes
    task automatic write_block(input logic [6:0] addr, input logic [7:0] cmd,
                               input logic [7:0] cnt, input bit do_stop);
        logic ack;
        bus_start();
        send_byte({addr, 1'b0}, ack);
        if (addr != 7'h69) begin
            chk("R2 mismatch nack", ack, 1'b0);
            for (int i = 0; i < wq.size(); i++) send_byte(wq[i], ack);
            bus_stop();
            return;
        end
        chk("R2 address ack", ack, 1'b1);
        send_byte(cmd, ack);
        chk("R3 command byte ack", ack, 1'b1);
        send_byte(cnt, ack);
        chk("R3 count byte ack", ack, 1'b1);
        for (int i = 0; i < wq.size(); i++) begin
            send_byte(wq[i], ack);
            if (i < 13) chk("R3 data ack", ack, 1'b1);
            else        chk("R5 overrun ack", ack, 1'b1);
            if (i < 11) mreg[i] = (i == 1) ? (wq[i] & 8'h07) : wq[i];
        end
        if (do_stop) bus_stop();
    endtask

    // Read: count byte then n registers, master NACKs the last
    task automatic read_regs(input int n);
        logic ack;
        logic [7:0] b;
        bus_start();
        send_byte({7'h69, 1'b1}, ack);
        chk("R2 read address ack", ack, 1'b1);
        recv_byte(1'b1, b);
        chk("R7 count byte", b, 8'h0D);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            if (i >= 11 && i < 13) chk("R6 id register", b, model_read(i));
            else if (i == 1)       chk("R6 strap readback", b, model_read(i));
            else                   chk("R7 read data", b, model_read(i));
        end
        tick(Q);
        chk("R7 sda released after nack", sda_oe, 1'b0);
        bus_stop();
    endtask

    initial begin
        model_reset();
        tick(6);
        rst_n = 1'b1;
        tick(2);
        chk("R1 sda idle", sda_oe, 1'b0);
        chk("R1 bank0 default", bank0, 8'hFF);
        chk("R1 reg5 default", {mem_skew, chip_skew, cpu_en}, 8'h93);
        quiet = 1'b1;
        tick(20);
        read_regs(13);

        // main writes with nonzero ignored bytes
        wq.delete();
        wq.push_back(8'hB9); wq.push_back(8'hFE); wq.push_back(8'h5A);
        wq.push_back(8'hC3); wq.push_back(8'h0F); wq.push_back(8'h6E);
        write_block(7'h69, 8'hA5, 8'h3C, 1'b1);
        tick(20);
        read_regs(14);

        // overrun past the identification registers
        wq.delete();
        for (int i = 0; i < 16; i++) wq.push_back(8'(8'h21 + i * 8'h13));
        write_block(7'h69, 8'h00, 8'hFF, 1'b1);
        tick(20);
        read_regs(13);

        // wrong address leaves everything alone
        wq.delete();
        wq.push_back(8'h00); wq.push_back(8'h00); wq.push_back(8'h00);
        wq.push_back(8'h00); wq.push_back(8'h00);
        write_block(7'h2A, 8'h00, 8'h00, 1'b1);
        tick(20);

        // R4 pointer rewinds after STOP
        wq.delete(); wq.push_back(8'h11); wq.push_back(8'h02);
        write_block(7'h69, 8'h07, 8'h02, 1'b1);
        wq.delete(); wq.push_back(8'h44);
        write_block(7'h69, 8'h07, 8'h01, 1'b1);
        tick(20);
        chk("R4 restart after stop", {sw_freq_sel, spread_on}, {1'b0, 1'b1, 4'h4, 1'b1});

        // R4 pointer rewinds after repeated START
        wq.delete(); wq.push_back(8'h55); wq.push_back(8'h33); wq.push_back(8'h77);
        write_block(7'h69, 8'h09, 8'h03, 1'b0);
        wq.delete(); wq.push_back(8'h66);
        write_block(7'h69, 8'h09, 8'h01, 1'b1);
        tick(20);
        chk("R4 restart after repeated start", {bank0, spread_quarter, spread_on, spread_center},
            {8'h77, 3'b011});

        // strap readback follows the pins
        strap = 5'b10010;
        tick(4);
        read_regs(2);

        // R1 defaults return only through reset
        quiet = 1'b0;
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        model_reset();
        tick(2);
        quiet = 1'b1;
        tick(20);
        chk("R1 default after second reset", {bank2, aux}, {8'hFF, 40'h0});

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R7 bus hung actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule